// File: doc/BRIEF.md
# Word Access Bank Splitter

This block sits between a core that asks for byte or word transfers and the sequencer that runs the bus cycles. Memory behind it has two byte-wide banks: even addresses live in the low bank and odd addresses live in the high bank. Each request is looked at once, on acceptance. The block then works out, from the address parity, the access size and the width of the external bus, whether one bus cycle is enough or two are needed. It issues those cycles in order and hands back a single result.

For every cycle it drives the byte address, including bit 0, and an active-high high-bank enable. A low address bit 0 selects the low bank. It also places the write byte or bytes on the right lanes of a 16-bit lane pair. Read bytes coming back from the lanes are merged into the result word. In narrow mode (8-bit external bus) everything travels on the low lane, and every word takes two cycles. Words on odd addresses take two cycles in both modes. I/O and memory requests are treated the same way.

The sequencer accepts a cycle by pulsing the acknowledge while the cycle is valid. It may hold the acknowledge low for any number of wait cycles first.

Top module: `bank_splitter`

## Requirements
- R1: While reset is high and on the first cycle after it, `cyc_valid`, `done` and `busy` are all 0.
- R2: In wide mode a word at an even address takes one cycle with address bit 0 = 0 and `cyc_hi_en` = 1. A write drives the whole request word on the lane pair. A read returns both lanes unchanged.
- R3: In wide mode a byte at an even address takes one cycle with `cyc_hi_en` = 0. The request byte (bits 7:0) goes on the low lane and the high lane carries 0. A read returns the low lane in bits 7:0 and zeros in bits 15:8.
- R4: In wide mode a byte at an odd address takes one cycle with address bit 0 = 1 and `cyc_hi_en` = 1. The request byte (bits 7:0) goes on the high lane and the low lane carries 0. A read returns the high lane in bits 7:0 and zeros in bits 15:8.
- R5: In wide mode a word at an odd address takes two cycles. The first is at the request address with `cyc_hi_en` = 1, and the word's low byte uses the high lane. The second is at the request address plus one with `cyc_hi_en` = 0, and the word's high byte uses the low lane.
- R6: In narrow mode (`narrow_bus` = 1) `cyc_hi_en` is always 0 and all data uses the low lane. A word takes two cycles, at the request address and then at the address plus one, carrying the low byte and then the high byte. A byte takes one cycle.
- R7: `done` pulses high for exactly one cycle, on the cycle after the acknowledge of the final bus cycle, and `rdata` holds the merged read word while it is high. It is never high earlier.
- R8: While `cyc_valid` is high and `cyc_ack` is low, the cycle's address, enable, direction and lanes stay unchanged.
- R9: A request presented while `busy` is high is ignored. It produces no bus cycle and does not alter the one in progress.
- R10: The address of a second cycle wraps modulo 2^ADDR_W, so a word at the highest odd address continues at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| narrow_bus | input | 1 | 1 = 8-bit external bus, sampled when a request is accepted |
| req_valid | input | 1 | Request present, accepted when `busy` is 0 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = single byte |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | 2*BYTE_W | Write data; a byte uses bits 7:0 |
| busy | output | 1 | A request is in progress |
| cyc_valid | output | 1 | A bus cycle is requested |
| cyc_write | output | 1 | Direction of the bus cycle |
| cyc_addr | output | ADDR_W | Byte address of the cycle; bit 0 low selects the low bank |
| cyc_hi_en | output | 1 | Active-high high-bank enable |
| cyc_wlanes | output | 2*BYTE_W | Write lanes; high lane in the upper byte |
| cyc_ack | input | 1 | Bus cycle finished, valid only with `cyc_valid` |
| cyc_rlanes | input | 2*BYTE_W | Read lanes, sampled with `cyc_ack` |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 2*BYTE_W | Merged read result, valid with `done` |

## Verification
The stimulus covers every combination of size and address parity in both bus modes: aligned and odd words, even and odd bytes, reads and writes. This separates the one-cycle outcomes from the two-cycle ones and shows which lane and which enable each case uses. Read lanes carry distinct filler in the unused lane, so a wrong lane choice or a swapped byte order in the merged word shows up in the result. Wait cycles before an acknowledge test that the cycle stays stable and that completion waits for the final acknowledge. A word at the top odd address tests address wrap. A request pushed in while busy must leave the running transfer untouched and start nothing afterwards.

// File: rtl/bsplit_pkg.sv
`timescale 1ns/1ps
package bsplit_pkg;
  typedef enum logic {
    STEP_FIRST  = 1'b0,
    STEP_SECOND = 1'b1
  } step_e;
endpackage

// File: rtl/bsplit_plan.sv
`timescale 1ns/1ps
// Derives the attributes of one bus cycle from the request and the step.
module bsplit_plan #(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              word,
  input  logic              narrow,
  input  bsplit_pkg::step_e step,
  output logic [ADDR_W-1:0] addr,
  output logic              two_step,
  output logic              full_word,
  output logic              lane_hi,
  output logic              hi_en
);
  always_comb begin
    addr      = base_addr + ADDR_W'(step == bsplit_pkg::STEP_SECOND);
    two_step  = word && (narrow || base_addr[0]);
    full_word = word && !narrow && !base_addr[0];
    lane_hi   = !narrow && addr[0];
    hi_en     = full_word || lane_hi;
  end
endmodule

// File: rtl/bsplit_steer.sv
`timescale 1ns/1ps
// Places write bytes on the lane pair.
module bsplit_steer #(
  parameter int BYTE_W = 8
) (
  input  logic [2*BYTE_W-1:0] wdata,
  input  bsplit_pkg::step_e   step,
  input  logic                full_word,
  input  logic                lane_hi,
  output logic [2*BYTE_W-1:0] lanes
);
  logic [BYTE_W-1:0] sel_byte;

  always_comb begin
    sel_byte = (step == bsplit_pkg::STEP_SECOND) ? wdata[2*BYTE_W-1:BYTE_W]
                                                 : wdata[BYTE_W-1:0];
    if (full_word)    lanes = wdata;
    else if (lane_hi) lanes = {sel_byte, {BYTE_W{1'b0}}};
    else              lanes = {{BYTE_W{1'b0}}, sel_byte};
  end
endmodule

// File: rtl/bsplit_merge.sv
`timescale 1ns/1ps
// Accumulates read bytes into the result word.
module bsplit_merge #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                capture,
  input  logic [2*BYTE_W-1:0] lanes,
  input  logic                full_word,
  input  logic                lane_hi,
  input  bsplit_pkg::step_e   step,
  output logic [2*BYTE_W-1:0] acc
);
  logic [BYTE_W-1:0] in_byte;

  always_comb begin
    in_byte = lane_hi ? lanes[2*BYTE_W-1:BYTE_W] : lanes[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc <= '0;
    end else if (capture) begin
      if (full_word)
        acc <= lanes;
      else if (step == bsplit_pkg::STEP_SECOND)
        acc[2*BYTE_W-1:BYTE_W] <= in_byte;
      else
        acc[BYTE_W-1:0] <= in_byte;
    end
  end
endmodule

// File: rtl/bank_splitter.sv
`timescale 1ns/1ps
module bank_splitter #(
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  narrow_bus,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic                  req_word,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [2*BYTE_W-1:0]   req_wdata,
  output logic                  busy,
  output logic                  cyc_valid,
  output logic                  cyc_write,
  output logic [ADDR_W-1:0]     cyc_addr,
  output logic                  cyc_hi_en,
  output logic [2*BYTE_W-1:0]   cyc_wlanes,
  input  logic                  cyc_ack,
  input  logic [2*BYTE_W-1:0]   cyc_rlanes,
  output logic                  done,
  output logic [2*BYTE_W-1:0]   rdata
);
  import bsplit_pkg::*;
  localparam int DATA_W = 2 * BYTE_W;

  // held request
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] wdata_q;
  logic              word_q, narrow_q, two_q;
  step_e             step_q;
  logic              full_q, lane_hi_q;

  logic accept, fire, last;
  assign accept = req_valid && !busy;
  assign fire   = cyc_valid && cyc_ack;
  assign last   = !two_q || (step_q == STEP_SECOND);

  // plan input mux: a new request or the second half of the held one
  logic [ADDR_W-1:0] p_base;
  logic [DATA_W-1:0] p_wdata;
  logic              p_word, p_narrow;
  step_e             p_step;
  assign p_base   = accept ? req_addr   : base_q;
  assign p_wdata  = accept ? req_wdata  : wdata_q;
  assign p_word   = accept ? req_word   : word_q;
  assign p_narrow = accept ? narrow_bus : narrow_q;
  assign p_step   = accept ? STEP_FIRST : STEP_SECOND;

  logic [ADDR_W-1:0] pl_addr;
  logic              pl_two, pl_full, pl_lane_hi, pl_hi_en;
  logic [DATA_W-1:0] pl_lanes;

  bsplit_plan #(.ADDR_W(ADDR_W)) u_plan (
    .base_addr (p_base),
    .word      (p_word),
    .narrow    (p_narrow),
    .step      (p_step),
    .addr      (pl_addr),
    .two_step  (pl_two),
    .full_word (pl_full),
    .lane_hi   (pl_lane_hi),
    .hi_en     (pl_hi_en)
  );

  bsplit_steer #(.BYTE_W(BYTE_W)) u_steer (
    .wdata     (p_wdata),
    .step      (p_step),
    .full_word (pl_full),
    .lane_hi   (pl_lane_hi),
    .lanes     (pl_lanes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      cyc_valid  <= 1'b0;
      cyc_write  <= 1'b0;
      cyc_addr   <= '0;
      cyc_hi_en  <= 1'b0;
      cyc_wlanes <= '0;
      done       <= 1'b0;
      base_q     <= '0;
      wdata_q    <= '0;
      word_q     <= 1'b0;
      narrow_q   <= 1'b0;
      two_q      <= 1'b0;
      step_q     <= STEP_FIRST;
      full_q     <= 1'b0;
      lane_hi_q  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        base_q    <= req_addr;
        wdata_q   <= req_wdata;
        word_q    <= req_word;
        narrow_q  <= narrow_bus;
        cyc_write <= req_write;
        two_q     <= pl_two;
        step_q    <= STEP_FIRST;
        busy      <= 1'b1;
        cyc_valid <= 1'b1;
      end else if (fire) begin
        if (last) begin
          cyc_valid <= 1'b0;
          busy      <= 1'b0;
          done      <= 1'b1;
        end else begin
          step_q <= STEP_SECOND;
        end
      end
      if (accept || (fire && !last)) begin
        cyc_addr   <= pl_addr;
        cyc_hi_en  <= pl_hi_en;
        cyc_wlanes <= pl_lanes;
        full_q     <= pl_full;
        lane_hi_q  <= pl_lane_hi;
      end
    end
  end

  bsplit_merge #(.BYTE_W(BYTE_W)) u_merge (
    .clk       (clk),
    .rst       (rst),
    .clear     (accept),
    .capture   (fire),
    .lanes     (cyc_rlanes),
    .full_word (full_q),
    .lane_hi   (lane_hi_q),
    .step      (step_q),
    .acc       (rdata)
  );
endmodule

// File: rtl/bsplit_checker.sv
`timescale 1ns/1ps
module bsplit_checker #(
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                narrow_bus,
  input logic                busy,
  input logic                cyc_valid,
  input logic                cyc_write,
  input logic [ADDR_W-1:0]   cyc_addr,
  input logic                cyc_hi_en,
  input logic [2*BYTE_W-1:0] cyc_wlanes,
  input logic                cyc_ack,
  input logic                done
);
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!cyc_valid && !done && !busy));

  p_hold_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && !cyc_ack) |=> (cyc_valid && $stable(cyc_addr) &&
      $stable(cyc_hi_en) && $stable(cyc_wlanes) && $stable(cyc_write)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_ack_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(cyc_valid && cyc_ack));

  p_narrow_low_lane_r6: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && narrow_bus) |-> !cyc_hi_en);

  p_odd_uses_high_r4: assert property (@(posedge clk) disable iff (rst)
    (cyc_valid && !narrow_bus && cyc_addr[0]) |-> cyc_hi_en);

  p_cycle_only_busy_r9: assert property (@(posedge clk) disable iff (rst)
    cyc_valid |-> busy);
endmodule

bind bank_splitter bsplit_checker #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/bank_splitter_bench.sv
`timescale 1ns/1ps
module bank_splitter_bench;
  localparam int AW = 20;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          narrow_bus = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic          req_word = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic          busy, cyc_valid, cyc_write, cyc_hi_en, done;
  logic [AW-1:0] cyc_addr;
  logic [15:0]   cyc_wlanes, rdata;
  logic          cyc_ack = 1'b0;
  logic [15:0]   cyc_rlanes = '0;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bank_splitter #(.ADDR_W(AW), .BYTE_W(BW)) u_bank_splitter (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic start(input bit nb, input bit wr, input bit wd,
                       input logic [AW-1:0] a, input logic [15:0] wv);
    @(negedge clk);
    narrow_bus = nb; req_write = wr; req_word = wd; req_addr = a; req_wdata = wv;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic bus_cycle(input string tag, input logic [AW-1:0] ea,
                           input bit ehi, input bit chk_wl, input logic [15:0] ewl,
                           input logic [15:0] rl, input int waits);
    check(cyc_valid === 1'b1, {tag, " cycle valid"}, 32'(cyc_valid), 1);
    check(cyc_addr === ea, {tag, " address"}, 32'(cyc_addr), 32'(ea));
    check(cyc_hi_en === ehi, {tag, " high enable"}, 32'(cyc_hi_en), 32'(ehi));
    if (chk_wl) check(cyc_wlanes === ewl, {tag, " lanes"}, 32'(cyc_wlanes), 32'(ewl));
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      check(cyc_valid === 1'b1 && cyc_addr === ea, {tag, " R8 hold"},
            32'(cyc_addr), 32'(ea));
      check(done === 1'b0, {tag, " R7 no early done"}, 32'(done), 0);
    end
    cyc_rlanes = rl;
    cyc_ack = 1'b1;
    @(negedge clk);
    cyc_ack = 1'b0;
    cyc_rlanes = 16'hxxxx;
  endtask

  task automatic finish_req(input string tag, input bit chk_rd, input logic [15:0] erd);
    check(done === 1'b1, {tag, " R7 done"}, 32'(done), 1);
    check(busy === 1'b0 && cyc_valid === 1'b0, {tag, " idle after"}, 32'(cyc_valid), 0);
    if (chk_rd) check(rdata === erd, {tag, " result"}, 32'(rdata), 32'(erd));
    @(negedge clk);
    check(done === 1'b0, {tag, " R7 single pulse"}, 32'(done), 0);
  endtask

  task automatic t_reset();
    check(cyc_valid === 0 && done === 0 && busy === 0, "R1 reset state",
          {29'd0, cyc_valid, done, busy}, 0);
  endtask

  task automatic t_aligned_word();
    start(0, 1, 1, 20'h00400, 16'hA55A);
    bus_cycle("R2 aligned write", 20'h00400, 1, 1, 16'hA55A, 16'h0000, 2);
    finish_req("R2 aligned write", 0, 0);
    start(0, 0, 1, 20'h00402, 16'h0000);
    bus_cycle("R2 aligned read", 20'h00402, 1, 0, 0, 16'hBEEF, 1);
    finish_req("R2 aligned read", 1, 16'hBEEF);
  endtask

  task automatic t_even_byte();
    start(0, 1, 0, 20'h00010, 16'h775C);
    bus_cycle("R3 even byte write", 20'h00010, 0, 1, 16'h005C, 16'h0000, 0);
    finish_req("R3 even byte write", 0, 0);
    start(0, 0, 0, 20'h00010, 16'h0000);
    bus_cycle("R3 even byte read", 20'h00010, 0, 0, 0, 16'h9A3C, 0);
    finish_req("R3 even byte read", 1, 16'h003C);
  endtask

  task automatic t_odd_byte();
    start(0, 1, 0, 20'h00011, 16'h11C3);
    bus_cycle("R4 odd byte write", 20'h00011, 1, 1, 16'hC300, 16'h0000, 1);
    finish_req("R4 odd byte write", 0, 0);
    start(0, 0, 0, 20'h00011, 16'h0000);
    bus_cycle("R4 odd byte read", 20'h00011, 1, 0, 0, 16'h9A3C, 0);
    finish_req("R4 odd byte read", 1, 16'h009A);
  endtask

  task automatic t_misaligned();
    start(0, 0, 1, 20'h01231, 16'h0000);
    bus_cycle("R5 odd word read c1", 20'h01231, 1, 0, 0, 16'h34EE, 1);
    check(done === 1'b0, "R7 no done between cycles", 32'(done), 0);
    bus_cycle("R5 odd word read c2", 20'h01232, 0, 0, 0, 16'hDD12, 2);
    finish_req("R5 odd word read", 1, 16'h1234);
    start(0, 1, 1, 20'h00033, 16'hBEAD);
    bus_cycle("R5 odd word write c1", 20'h00033, 1, 1, 16'hAD00, 16'h0000, 0);
    bus_cycle("R5 odd word write c2", 20'h00034, 0, 1, 16'h00BE, 16'h0000, 0);
    finish_req("R5 odd word write", 0, 0);
  endtask

  task automatic t_narrow();
    start(1, 0, 1, 20'h00100, 16'h0000);
    bus_cycle("R6 narrow word read c1", 20'h00100, 0, 0, 0, 16'hFF78, 0);
    bus_cycle("R6 narrow word read c2", 20'h00101, 0, 0, 0, 16'hFF56, 1);
    finish_req("R6 narrow word read", 1, 16'h5678);
    start(1, 1, 1, 20'h00201, 16'hCAFE);
    bus_cycle("R6 narrow word write c1", 20'h00201, 0, 1, 16'h00FE, 16'h0000, 0);
    bus_cycle("R6 narrow word write c2", 20'h00202, 0, 1, 16'h00CA, 16'h0000, 0);
    finish_req("R6 narrow word write", 0, 0);
    start(1, 0, 0, 20'h00203, 16'h0000);
    bus_cycle("R6 narrow odd byte read", 20'h00203, 0, 0, 0, 16'hAA42, 0);
    finish_req("R6 narrow odd byte read", 1, 16'h0042);
    narrow_bus = 1'b0;
  endtask

  task automatic t_wrap();
    start(0, 1, 1, 20'hFFFFF, 16'h1357);
    bus_cycle("R10 wrap c1", 20'hFFFFF, 1, 1, 16'h5700, 16'h0000, 0);
    bus_cycle("R10 wrap c2", 20'h00000, 0, 1, 16'h0013, 16'h0000, 0);
    finish_req("R10 wrap", 0, 0);
  endtask

  task automatic t_ignore_busy();
    start(0, 0, 1, 20'h00500, 16'h0000);
    @(negedge clk);
    req_write = 1'b1; req_word = 1'b0; req_addr = 20'h00777; req_wdata = 16'h00EE;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    bus_cycle("R9 busy request ignored", 20'h00500, 1, 0, 0, 16'h4321, 0);
    finish_req("R9 busy request ignored", 1, 16'h4321);
    for (int i = 0; i < 3; i++) begin
      check(cyc_valid === 1'b0 && busy === 1'b0, "R9 no extra cycle",
            32'(cyc_valid), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_aligned_word();
    t_even_byte();
    t_odd_byte();
    t_misaligned();
    t_narrow();
    t_wrap();
    t_ignore_busy();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule